// File: doc/BRIEF.md
# Prioritized Core Interrupt Arbiter

This block gathers nine level-sensitive hardware interrupt sources for one processor core into a pending register. Each cycle it looks for the highest-ranked pending source that the current machine-state enables allow. When it finds one, it presents that source as a "take exception" request with a 4-bit exception code and a zero error code. The request is held until the core accepts it. On acceptance, only that source's pending bit is cleared.

A summary request line stays high while any pending bit is set. A wake output tells a halted core to resume. A small front-end turns events from an external interrupt controller into pending-bit updates. One of those events instead becomes a one-cycle system-reset request.

The ranking is not a plain index encoder. Source 0 is always eligible. Source 1 needs the machine-check enable. The timer group and the external source need the external enable. Source 8 can be pending but is never selected.

Top module: `irq_arbiter`

## Requirements
- R1: Source bit assignment is fixed: 0 reset/critical, 1 machine check, 2 external, 3 decrementer, 4 hypervisor decrementer, 5 programmable interval timer, 6 fixed interval timer, 7 watchdog, 8 debug. A one-cycle pulse on `srcSet[n]` sets pending bit n, and `hwReq` is high from the next cycle.
- R2: A pulse on `srcClr[n]` clears pending bit n. `hwReq` falls only once every pending bit is zero.
- R3: When `srcSet[n]` and `srcClr[n]` are asserted in the same cycle, bit n ends up set.
- R4: Pending bit 0 is taken before any other source, whatever the enables. Bit 1 is taken next, but only while `mcEnable` is high.
- R5: When neither bit 0 nor bit 1 is taken and `extEnable` is high, the search order is 4, 3, 5, 6, 7, 2. Bit 4 takes part only when parameter `HYP_EN` is nonzero, and `HYP_EN` defaults to 0.
- R6: `takeValid` rises one cycle after an eligible source is pending. `takeCode` equals the source index and reads 15 when idle. `takeErr` is zero. The request and its code stay unchanged until a cycle with `takeAck` high. That cycle clears only the taken bit, unless the same bit is set in that cycle, in which case it remains pending.
- R7: After an acceptance, `hwReq` stays high while any other bit is pending.
- R8: Pending bit 8 can be set and cleared but is never presented.
- R9: Controller events (`evtIdx`) map onto pending bits as follows: 0 to bit 2, 1 to bit 0, 2 to bit 1, 3 to bit 8. `evtLevel` high sets the bit and low clears it.
- R10: Event 4 with level high produces a one-cycle `sysResetReq` pulse in the next cycle and leaves the pending bits untouched. Events 5 to 7 are ignored.
- R11: `wake` is high only while `halted`, `extEnable` and `hwReq` are all high.
- R12: Synchronous reset clears all pending bits, `hwReq`, `takeValid` and `sysResetReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| srcSet | input | 9 | Per-source raise strobes |
| srcClr | input | 9 | Per-source lower strobes |
| evtValid | input | 1 | Controller event strobe |
| evtIdx | input | EVT_W (3) | Controller event index |
| evtLevel | input | 1 | Controller event level |
| mcEnable | input | 1 | Machine-check enable |
| extEnable | input | 1 | External/timer interrupt enable |
| halted | input | 1 | Core is halted |
| takeAck | input | 1 | Core accepts the presented exception |
| hwReq | output | 1 | Summary request: any bit pending |
| takeValid | output | 1 | Exception being presented |
| takeCode | output | 4 | Source index of the presented exception, 15 when idle |
| takeErr | output | ERR_W (8) | Error code reported with the exception |
| wake | output | 1 | Resume request for a halted core |
| sysResetReq | output | 1 | One-cycle system-reset request |

## Verification
Some properties are checked on every cycle. A presented exception must stay stable until it is accepted. A machine-check or enable-gated source may be presented only if its enable was high when the selection was made. Source 8, and source 4 when it is disabled, must never appear. A same-cycle set must override a clear. An accepted service must clear its own bit. The reset event must yield its pulse without touching the pending bits. Only the bench scenarios can show the complete service order across many pending bits. They also show that event indices land on the right bits, that the summary line outlives a single service, and how wake depends on the enable.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

  localparam int NUM_SRC = 9;
  localparam int CODE_W  = 4;
  localparam int IDX_W   = 4;

  typedef enum logic [CODE_W-1:0] {
    CODE_RST  = 4'd0,
    CODE_MCK  = 4'd1,
    CODE_EXT  = 4'd2,
    CODE_DEC  = 4'd3,
    CODE_HDEC = 4'd4,
    CODE_PIT  = 4'd5,
    CODE_FIT  = 4'd6,
    CODE_WDOG = 4'd7,
    CODE_DBG  = 4'd8,
    CODE_NONE = 4'd15
  } excCode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic             svc;
    logic [IDX_W-1:0] svcIdx;
  } ctrlStrobe_t;

endpackage

// File: rtl/irqEventMap.sv
module irqEventMap import irq_arb_pkg::*; #(
  parameter int EVT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evtValid,
  input  logic [EVT_W-1:0]   evtIdx,
  input  logic               evtLevel,
  output logic [NUM_SRC-1:0] evtSet,
  output logic [NUM_SRC-1:0] evtClr,
  output logic               sysResetReq
);

  localparam logic [EVT_W-1:0] EVT_NORMAL = EVT_W'(0);
  localparam logic [EVT_W-1:0] EVT_CRIT   = EVT_W'(1);
  localparam logic [EVT_W-1:0] EVT_MCHK   = EVT_W'(2);
  localparam logic [EVT_W-1:0] EVT_DEBUG  = EVT_W'(3);
  localparam logic [EVT_W-1:0] EVT_SYSRST = EVT_W'(4);

  logic [NUM_SRC-1:0] evtMask;
  logic               rstEvt;

  always_comb begin
    evtMask = '0;
    if (evtValid) begin
      case (evtIdx)
        EVT_NORMAL: evtMask[CODE_EXT] = 1'b1;
        EVT_CRIT:   evtMask[CODE_RST] = 1'b1;
        EVT_MCHK:   evtMask[CODE_MCK] = 1'b1;
        EVT_DEBUG:  evtMask[CODE_DBG] = 1'b1;
        default:    evtMask = '0;
      endcase
    end
  end

  assign evtSet = evtLevel ? evtMask : '0;
  assign evtClr = evtLevel ? '0 : evtMask;
  assign rstEvt = evtValid && evtLevel && (evtIdx == EVT_SYSRST);

  always_ff @(posedge clk) begin
    if (rst) sysResetReq <= 1'b0;
    else     sysResetReq <= rstEvt;
  end

  // R10: reset event yields a pulse and no pending update
  a_r10_reset_pulse: assert property (@(posedge clk) disable iff (rst)
    rstEvt |=> sysResetReq);
  a_r10_reset_no_pending: assert property (@(posedge clk) disable iff (rst)
    rstEvt |-> (evtSet == '0 && evtClr == '0));

endmodule

// File: rtl/irqPendingDp.sv
module irqPendingDp import irq_arb_pkg::*; (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcSet,
  input  logic [NUM_SRC-1:0] srcClr,
  input  logic [NUM_SRC-1:0] evtSet,
  input  logic [NUM_SRC-1:0] evtClr,
  input  ctrlStrobe_t        strobe,
  output logic [NUM_SRC-1:0] pend,
  output logic               hwReq
);

  logic [NUM_SRC-1:0] svcMask;
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] clrVec;

  assign svcMask = strobe.svc ? (NUM_SRC'(1) << strobe.svcIdx) : '0;
  assign setVec  = srcSet | evtSet;
  assign clrVec  = srcClr | evtClr | svcMask;

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clrVec) | setVec;
  end

  assign hwReq = |pend;

  // R1: a raise strobe makes the summary line high next cycle
  a_r1_set_raises_req: assert property (@(posedge clk) disable iff (rst)
    (|setVec) |=> hwReq);
  // R3: set beats any clear of the same bit
  a_r3_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (|(setVec & clrVec)) |=> ((pend & $past(setVec & clrVec)) == $past(setVec & clrVec)));
  // R6: an accepted service clears its own bit unless re-raised
  a_r6_service_clears: assert property (@(posedge clk) disable iff (rst)
    (|(svcMask & ~setVec)) |=> ((pend & $past(svcMask & ~setVec)) == '0));

endmodule

// File: rtl/irqArbCtrl.sv
module irqArbCtrl import irq_arb_pkg::*; #(
  parameter bit HYP_EN = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] pend,
  input  logic               mcEnable,
  input  logic               extEnable,
  input  logic               takeAck,
  output logic               takeValid,
  output excCode_e           takeCode,
  output ctrlStrobe_t        strobe
);

  localparam int N_GATED = 6;
  localparam int GATED_ORDER [N_GATED] = '{4, 3, 5, 6, 7, 2};

  logic             found;
  logic [IDX_W-1:0] selIdx;
  logic [IDX_W-1:0] heldIdx;

  always_comb begin
    found  = 1'b0;
    selIdx = '0;
    if (pend[CODE_RST]) begin
      found  = 1'b1;
      selIdx = IDX_W'(CODE_RST);
    end else if (mcEnable && pend[CODE_MCK]) begin
      found  = 1'b1;
      selIdx = IDX_W'(CODE_MCK);
    end else if (extEnable) begin
      // walk lowest rank first so the highest rank is assigned last
      for (int k = N_GATED - 1; k >= 0; k--) begin
        if (pend[GATED_ORDER[k]] && (HYP_EN || GATED_ORDER[k] != int'(CODE_HDEC))) begin
          found  = 1'b1;
          selIdx = IDX_W'(GATED_ORDER[k]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      takeValid <= 1'b0;
      heldIdx   <= '0;
    end else if (takeValid) begin
      if (takeAck) takeValid <= 1'b0;
    end else if (found) begin
      takeValid <= 1'b1;
      heldIdx   <= selIdx;
    end
  end

  assign takeCode      = takeValid ? excCode_e'(heldIdx) : CODE_NONE;
  assign strobe.svc    = takeValid && takeAck;
  assign strobe.svcIdx = heldIdx;

  // R6: presentation holds until accepted
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (takeValid && !takeAck) |=> (takeValid && $stable(takeCode)));
  // R4: machine check needs its enable at selection
  a_r4_mck_gated: assert property (@(posedge clk) disable iff (rst)
    ($rose(takeValid) && takeCode == CODE_MCK) |-> $past(mcEnable));
  // R5: timer and external group need the external enable
  a_r5_ext_gated: assert property (@(posedge clk) disable iff (rst)
    ($rose(takeValid) && takeCode != CODE_RST && takeCode != CODE_MCK) |-> $past(extEnable));
  a_r5_hyp_off: assert property (@(posedge clk) disable iff (rst)
    takeValid |-> (HYP_EN || takeCode != CODE_HDEC));
  // R8: debug source never presented
  a_r8_debug_never: assert property (@(posedge clk) disable iff (rst)
    takeValid |-> (takeCode != CODE_DBG && takeCode != CODE_NONE));

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter import irq_arb_pkg::*; #(
  parameter bit HYP_EN = 1'b0,
  parameter int EVT_W  = 3,
  parameter int ERR_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_SRC-1:0]      srcSet,
  input  logic [NUM_SRC-1:0]      srcClr,
  input  logic                    evtValid,
  input  logic [EVT_W-1:0]        evtIdx,
  input  logic                    evtLevel,
  input  logic                    mcEnable,
  input  logic                    extEnable,
  input  logic                    halted,
  input  logic                    takeAck,
  output logic                    hwReq,
  output logic                    takeValid,
  output logic [CODE_W-1:0]       takeCode,
  output logic [ERR_W-1:0]        takeErr,
  output logic                    wake,
  output logic                    sysResetReq
);

  logic [NUM_SRC-1:0] evtSet;
  logic [NUM_SRC-1:0] evtClr;
  logic [NUM_SRC-1:0] pend;
  ctrlStrobe_t        strobe;
  excCode_e           codeEnum;

  irqEventMap #(.EVT_W(EVT_W)) uEvt (
    .clk         (clk),
    .rst         (rst),
    .evtValid    (evtValid),
    .evtIdx      (evtIdx),
    .evtLevel    (evtLevel),
    .evtSet      (evtSet),
    .evtClr      (evtClr),
    .sysResetReq (sysResetReq)
  );

  irqPendingDp uDp (
    .clk    (clk),
    .rst    (rst),
    .srcSet (srcSet),
    .srcClr (srcClr),
    .evtSet (evtSet),
    .evtClr (evtClr),
    .strobe (strobe),
    .pend   (pend),
    .hwReq  (hwReq)
  );

  irqArbCtrl #(.HYP_EN(HYP_EN)) uCtrl (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .mcEnable  (mcEnable),
    .extEnable (extEnable),
    .takeAck   (takeAck),
    .takeValid (takeValid),
    .takeCode  (codeEnum),
    .strobe    (strobe)
  );

  assign takeCode = codeEnum;
  assign takeErr  = '0;
  assign wake     = halted && extEnable && hwReq;

endmodule

// File: tb/tb_irq_arbiter.sv
module tb_irq_arbiter;

  logic       clk = 1'b0;
  logic       rst;
  logic [8:0] srcSet, srcClr;
  logic       evtValid, evtLevel;
  logic [2:0] evtIdx;
  logic       mcEnable, extEnable, halted, takeAck;
  logic       hwReq, takeValid, wake, sysResetReq;
  logic [3:0] takeCode;
  logic [7:0] takeErr;

  int nChecks = 0;
  int nErr    = 0;
  int expQ[$];

  always #5 clk = ~clk;

  irq_arbiter dut (
    .clk(clk), .rst(rst), .srcSet(srcSet), .srcClr(srcClr),
    .evtValid(evtValid), .evtIdx(evtIdx), .evtLevel(evtLevel),
    .mcEnable(mcEnable), .extEnable(extEnable), .halted(halted),
    .takeAck(takeAck), .hwReq(hwReq), .takeValid(takeValid),
    .takeCode(takeCode), .takeErr(takeErr), .wake(wake),
    .sysResetReq(sysResetReq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  // monitor: every accepted exception is compared with the scoreboard
  always @(negedge clk) begin
    #3;
    if (!rst && takeValid && takeAck) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R6 unexpected take", int'(takeCode), -1);
      end else begin
        int e;
        e = expQ.pop_front();
        chk(int'(takeCode) == e, "R4/R5 service order", int'(takeCode), e);
        chk(takeErr == 8'd0, "R6 error code", int'(takeErr), 0);
      end
    end
  end

  initial begin
    #200000;
    chk(1'b0, "watchdog", 0, 1);
    finishRun();
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setBits(input logic [8:0] m);
    srcSet = m; @(negedge clk); srcSet = '0;
  endtask

  task automatic clrBits(input logic [8:0] m);
    srcClr = m; @(negedge clk); srcClr = '0;
  endtask

  task automatic evt(input int idx, input bit lvl);
    evtValid = 1'b1; evtIdx = 3'(idx); evtLevel = lvl;
    @(negedge clk);
    evtValid = 1'b0; evtLevel = 1'b0;
  endtask

  initial begin
    rst = 1'b1; srcSet = '0; srcClr = '0; evtValid = 0; evtIdx = '0; evtLevel = 0;
    mcEnable = 0; extEnable = 0; halted = 0; takeAck = 0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R12 reset state
    chk(!hwReq && !takeValid && !sysResetReq && !wake, "R12 reset outputs", int'(hwReq), 0);
    chk(takeCode == 4'd15, "R6 idle code", int'(takeCode), 15);

    // full order with bits 1..8 pending, enables off at first
    setBits(9'h1FE);
    chk(hwReq == 1'b1, "R1 summary after set", int'(hwReq), 1);
    cyc(3);
    chk(takeValid == 1'b0, "R4 nothing eligible without enables", int'(takeValid), 0);
    expQ.push_back(1); expQ.push_back(3); expQ.push_back(5);
    expQ.push_back(6); expQ.push_back(7); expQ.push_back(2);
    takeAck = 1; mcEnable = 1; extEnable = 1;
    cyc(20);
    chk(takeValid == 1'b0, "R8 debug bit not taken", int'(takeValid), 0);
    chk(hwReq == 1'b1, "R7 summary stays with bits left", int'(hwReq), 1);
    chk(expQ.size() == 0, "R5 all expected taken", expQ.size(), 0);
    clrBits(9'h100);
    chk(hwReq == 1'b1, "R5 bit4 skipped without HYP_EN", int'(hwReq), 1);
    clrBits(9'h010);
    chk(hwReq == 1'b0, "R2 summary drops when empty", int'(hwReq), 0);
    mcEnable = 0; extEnable = 0;

    // bit 0 regardless of enables, bit 1 blocked
    expQ.push_back(0);
    setBits(9'h003);
    cyc(5);
    chk(takeValid == 1'b0 && hwReq == 1'b1, "R4 mck blocked while disabled", int'(takeValid), 0);
    clrBits(9'h002);
    chk(hwReq == 1'b0, "R2 cleared", int'(hwReq), 0);

    // hold until accept, higher rank arriving meanwhile
    takeAck = 0; extEnable = 1;
    setBits(9'h008);
    cyc(2);
    chk(takeValid == 1'b1 && takeCode == 4'd3, "R6 presented", int'(takeCode), 3);
    setBits(9'h001);
    cyc(2);
    chk(takeValid == 1'b1 && takeCode == 4'd3, "R6 held stable", int'(takeCode), 3);
    expQ.push_back(3); expQ.push_back(0);
    takeAck = 1;
    cyc(6);
    chk(hwReq == 1'b0 && expQ.size() == 0, "R6 both serviced", int'(hwReq), 0);

    // service clear and new set in same cycle
    takeAck = 0;
    setBits(9'h020);
    cyc(2);
    expQ.push_back(5); expQ.push_back(5);
    takeAck = 1; srcSet = 9'h020;
    @(negedge clk);
    srcSet = '0;
    cyc(5);
    chk(hwReq == 1'b0 && expQ.size() == 0, "R6 re-set bit taken again", expQ.size(), 0);
    extEnable = 0;

    // set wins over clear
    srcSet = 9'h040; srcClr = 9'h040;
    @(negedge clk);
    srcSet = '0; srcClr = '0;
    chk(hwReq == 1'b1, "R3 set wins", int'(hwReq), 1);
    clrBits(9'h040);
    chk(hwReq == 1'b0, "R2 clear after", int'(hwReq), 0);

    // controller event mapping
    evt(0, 1);
    chk(hwReq == 1'b1, "R9 event 0 sets", int'(hwReq), 1);
    evt(0, 0);
    chk(hwReq == 1'b0, "R9 event 0 low clears", int'(hwReq), 0);
    expQ.push_back(0); expQ.push_back(1); expQ.push_back(2);
    evt(0, 1); evt(1, 1); evt(2, 1); evt(3, 1);
    cyc(3);
    mcEnable = 1; extEnable = 1;
    cyc(8);
    chk(expQ.size() == 0, "R9 mapped bits serviced in order", expQ.size(), 0);
    chk(hwReq == 1'b1, "R9 event 3 holds debug bit", int'(hwReq), 1);
    evt(3, 0);
    chk(hwReq == 1'b0, "R9 event 3 low clears", int'(hwReq), 0);
    mcEnable = 0; extEnable = 0;

    // reset event
    evt(4, 1);
    chk(sysResetReq == 1'b1, "R10 reset pulse", int'(sysResetReq), 1);
    chk(hwReq == 1'b0, "R10 pending untouched", int'(hwReq), 0);
    cyc(1);
    chk(sysResetReq == 1'b0, "R10 pulse one cycle", int'(sysResetReq), 0);
    evt(5, 1);
    chk(hwReq == 1'b0 && sysResetReq == 1'b0, "R10 event 5 ignored", int'(hwReq), 0);

    // wake
    halted = 1;
    setBits(9'h100);
    chk(wake == 1'b0, "R11 no wake without enable", int'(wake), 0);
    extEnable = 1;
    cyc(1);
    chk(wake == 1'b1, "R11 wake", int'(wake), 1);
    clrBits(9'h100);
    chk(wake == 1'b0, "R11 no wake without request", int'(wake), 0);
    halted = 0; extEnable = 0;

    // reset mid-run
    setBits(9'h104);
    rst = 1;
    cyc(1);
    rst = 0;
    cyc(1);
    chk(hwReq == 1'b0 && takeValid == 1'b0, "R12 reset clears pending", int'(hwReq), 0);
    chk(expQ.size() == 0, "R6 scoreboard drained", expQ.size(), 0);
    finishRun();
  end

endmodule